// File: doc/BRIEF.md
# Two-Channel Indirect Register Pointer and Command Decoder

This block sits behind a single byte-wide control port and gives a host indirect access to sixteen write registers and sixteen read registers in each of two channels. The host first writes a byte while the channel's pointer is at zero. That byte is split into three fields: a register index, a command code and a reset code. The next control access on the same channel, read or write, goes to the register that was selected. After that access the pointer goes back to zero. The upper eight registers can only be selected when the command field carries the point-high code.

Commands and reset codes are turned into single-cycle strobes for the serial logic of that channel. The write registers are held in flops and presented as one flat vector. The read registers come from outside the block as a flat status vector and are returned through a registered read path. Write index 2 and write index 9 are each one register shared by both channels. Read index 3 carries data only on channel 0.

The control port has no back-pressure. Every strobe is accepted in the cycle it is presented. The port uses plain strobes and not a valid/ready pair, because it never stalls.

Top module: `ireg_cmd_port`

## Requirements
- R1: While reset is asserted and after it is released, both channel pointers are zero, every write register reads 0x00, every command and reset strobe is low, and `host_rvalid` is low.
- R2: A write at pointer zero selects register bits [2:0] of the byte. If the selected index is nonzero, the next write on that channel stores the byte into that channel's write register. The write register for channel c, index i appears at `wreg_q[(c*16+i)*8 +: 8]`.
- R3: When the command field (byte bits [5:3]) equals 1 (point high, byte 0x08), the selected index is the value of bits [2:0] plus 8.
- R4: After any read or write that reaches a nonzero register, the channel pointer is zero again.
- R5: A command field value k from 2 to 7, written at pointer zero, raises `cmd_stb[c*6 + k-2]` for exactly the cycle after the write. The codes are: 2 clear external/status interrupt, 3 send abort, 4 arm interrupt on next received character, 5 clear transmit interrupt, 6 clear error condition, 7 clear highest in-service interrupt. Command values 0 and 1 raise no strobe.
- R6: A reset field value r from 1 to 3 (byte bits [7:6]), written at pointer zero, raises `rst_stb[c*3 + r-1]` for the cycle after the write. The codes are: 1 receive CRC checker, 2 transmit CRC generator, 3 transmit underrun/end-of-message latch. One byte can carry a reset code, a command and a register select at the same time.
- R7: A read at a nonzero pointer returns `stat_rd[(c*16+i)*8 +: 8]` on `host_rdata`, with `host_rvalid` high for the cycle after the read. It never returns write register contents.
- R8: A read at pointer zero returns read register 0 of that channel and leaves the pointer at zero.
- R9: Write indices 2 and 9 are each one register for both channels. A write through either channel shows up in both channels' slices of `wreg_q`.
- R10: Read index 3 returns status only on channel 0. On channel 1 it returns 0x00.
- R11: When `host_wr` and `host_rd` are high together, the write is performed and the read is ignored, so `host_rvalid` stays low.
- R12: Write index 0 holds no data, and its slices of `wreg_q` stay 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ch | input | 1 | Channel addressed by the current access |
| host_wr | input | 1 | Control write strobe |
| host_rd | input | 1 | Control read strobe |
| host_wdata | input | 8 | Control write byte |
| host_rdata | output | 8 | Read result, updated the cycle after a read |
| host_rvalid | output | 1 | High for one cycle when host_rdata carries a new read result |
| stat_rd | input | 256 | Read register contents, 16 bytes per channel |
| wreg_q | output | 256 | Write register contents, 16 bytes per channel |
| cmd_stb | output | 12 | Command strobes, 6 per channel |
| rst_stb | output | 6 | Reset-code strobes, 3 per channel |

## Verification
Some properties are checked on every cycle by the assertions. At most one command strobe and one reset strobe fire per channel, and every strobe follows a pointer-zero write. The pointer clears after an access to a nonzero register and stays at zero on a status read. `host_rvalid` only ever follows a read that did not collide with a write. Shared index 2 tracks the last byte written to it. The channel-specific read of index 3 returns zero on channel 1. Other behaviours need the directed scenarios to show them: the exact strobe position for each code, the point-high offset reaching registers 8 to 15, read and write paths being separate at the same index, channel isolation, and a hardware reset abandoning a pending selection.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  localparam int DW    = 8;
  localparam int NREG  = 16;
  localparam int PW    = $clog2(NREG);
  localparam int LOW_W = 3;
  localparam int NCMD  = 6;
  localparam int NRST  = 3;
  localparam int CMD_BASE = 2;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_PT_HIGH = 3'd1,
    CMD_CLR_EXT = 3'd2,
    CMD_ABORT   = 3'd3,
    CMD_ARM_RX  = 3'd4,
    CMD_CLR_TX  = 3'd5,
    CMD_CLR_ERR = 3'd6,
    CMD_CLR_IUS = 3'd7
  } cmd_e;

  function automatic bit is_shared(int idx);
    return (idx == 2) || (idx == 9);
  endfunction
endpackage

// File: rtl/ireg_ptr_unit.sv
module ireg_ptr_unit
  import ireg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [PW-1:0]   ptr_o,
  output logic [NCMD-1:0] cmd_stb_o,
  output logic [NRST-1:0] rst_stb_o
);
  cmd_e          cmd;
  logic [1:0]    rcode;
  logic [PW-1:0] sel;
  logic          at_base;

  always_comb begin
    cmd     = cmd_e'(wdata_i[5:3]);
    rcode   = wdata_i[7:6];
    sel     = PW'(wdata_i[LOW_W-1:0]);
    if (cmd == CMD_PT_HIGH) sel = sel | PW'(1 << LOW_W);
    at_base = (ptr_o == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_o     <= '0;
      cmd_stb_o <= '0;
      rst_stb_o <= '0;
    end else begin
      cmd_stb_o <= '0;
      rst_stb_o <= '0;
      if (wr_i) begin
        if (at_base) begin
          ptr_o <= sel;
          for (int k = 0; k < NCMD; k++)
            cmd_stb_o[k] <= (int'(cmd) == k + CMD_BASE);
          for (int r = 0; r < NRST; r++)
            rst_stb_o[r] <= (int'(rcode) == r + 1);
        end else begin
          ptr_o <= '0;
        end
      end else if (rd_i && !at_base) begin
        ptr_o <= '0;
      end
    end
  end

  a_r4_ptr_returns: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_i || rd_i) && ptr_o != '0) |=> (ptr_o == '0));
  a_r8_status_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && ptr_o == '0) |=> (ptr_o == '0));
  a_r5_cmd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_stb_o));
  a_r6_rst_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rst_stb_o));
  a_r5_cmd_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb_o != '0 || rst_stb_o != '0) |-> $past(wr_i && ptr_o == '0));
endmodule

// File: rtl/ireg_wfile.sv
module ireg_wfile
  import ireg_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [CW-1:0]         wch_i,
  input  logic [PW-1:0]         widx_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [NCH*NREG*DW-1:0] wreg_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar i = 0; i < NREG; i++) begin : g_cell
      logic [DW-1:0] q;
      if (i == 0) begin : g_none
        assign q = '0;
      end else if (is_shared(i) && c != 0) begin : g_alias
        assign q = g_ch[0].g_cell[i].q;
      end else begin : g_flop
        always_ff @(posedge clk) begin
          if (!rst_n) q <= '0;
          else if (we_i && widx_i == PW'(i) && (is_shared(i) || int'(wch_i) == c))
            q <= wdata_i;
        end
      end
      assign wreg_o[(c*NREG+i)*DW +: DW] = q;
    end
  end

  a_r9_shared_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && widx_i == PW'(2)) |=> (g_ch[NCH-1].g_cell[2].q == $past(wdata_i)));
endmodule

// File: rtl/ireg_cmd_port.sv
module ireg_cmd_port
  import ireg_pkg::*;
#(
  parameter int NCH = 2,
  parameter int IPEND_CH = 0,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CW-1:0]          host_ch,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [DW-1:0]          host_wdata,
  output logic [DW-1:0]          host_rdata,
  output logic                   host_rvalid,
  input  logic [NCH*NREG*DW-1:0] stat_rd,
  output logic [NCH*NREG*DW-1:0] wreg_q,
  output logic [NCH*NCMD-1:0]    cmd_stb,
  output logic [NCH*NRST-1:0]    rst_stb
);
  localparam int IPEND_IDX = 3;

  logic [PW-1:0] ptr_w [NCH];
  logic [PW-1:0] cur_ptr;
  logic          rd_go;
  logic [DW-1:0] rd_val;

  assign rd_go = host_rd && !host_wr;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ireg_ptr_unit u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (host_wr && int'(host_ch) == c),
      .rd_i      (rd_go && int'(host_ch) == c),
      .wdata_i   (host_wdata),
      .ptr_o     (ptr_w[c]),
      .cmd_stb_o (cmd_stb[c*NCMD +: NCMD]),
      .rst_stb_o (rst_stb[c*NRST +: NRST])
    );
  end

  assign cur_ptr = ptr_w[host_ch];

  ireg_wfile #(.NCH(NCH)) u_wfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (host_wr && cur_ptr != '0),
    .wch_i   (host_ch),
    .widx_i  (cur_ptr),
    .wdata_i (host_wdata),
    .wreg_o  (wreg_q)
  );

  always_comb begin
    rd_val = stat_rd[(int'(host_ch)*NREG + int'(cur_ptr))*DW +: DW];
    if (int'(cur_ptr) == IPEND_IDX && int'(host_ch) != IPEND_CH) rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rd_go;
      if (rd_go) host_rdata <= rd_val;
    end
  end

  a_r11_collide_drops_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_rd) |=> !host_rvalid);
  a_r7_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_rd && !host_wr));
  a_r10_ipend_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && int'(cur_ptr) == IPEND_IDX && int'(host_ch) != IPEND_CH)
      |=> (host_rdata == '0));
endmodule

// File: tb/ireg_cmd_port_bench.sv
`timescale 1ns/1ps
module ireg_cmd_port_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [0:0]   host_ch = '0;
  logic         host_wr = 1'b0;
  logic         host_rd = 1'b0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic         host_rvalid;
  logic [255:0] stat_rd;
  logic [255:0] wreg_q;
  logic [11:0]  cmd_stb;
  logic [5:0]   rst_stb;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0]  c_rdata;
  logic        c_rvalid;
  logic [11:0] c_cmd;
  logic [5:0]  c_rst;

  always #2 clk = ~clk;

  ireg_cmd_port u_ireg_cmd_port (
    .clk(clk), .rst_n(rst_n), .host_ch(host_ch), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .stat_rd(stat_rd), .wreg_q(wreg_q),
    .cmd_stb(cmd_stb), .rst_stb(rst_stb)
  );

  function automatic logic [7:0] sbyte(int c, int i);
    return 8'((c*16 + i) ^ 8'hA0);
  endfunction

  function automatic logic [7:0] wbyte(int c, int i);
    return wreg_q[(c*16+i)*8 +: 8];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(int ch, bit wr, bit rd, logic [7:0] d);
    @(negedge clk);
    host_ch = 1'(ch); host_wr = wr; host_rd = rd; host_wdata = d;
    @(posedge clk); #1;
    c_rdata = host_rdata; c_rvalid = host_rvalid; c_cmd = cmd_stb; c_rst = rst_stb;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
  endtask

  task automatic t_reset;
    check("R1 wreg", 32'(wreg_q == '0), 1);
    check("R1 cmd", 32'(cmd_stb), 0);
    check("R1 rst", 32'(rst_stb), 0);
    check("R1 rvalid", 32'(host_rvalid), 0);
  endtask

  task automatic t_select_write;
    op(0, 1, 0, 8'h05); op(0, 1, 0, 8'hA5);
    check("R2 ch0 reg5", 32'(wbyte(0, 5)), 32'hA5);
    check("R2 ch1 reg5 untouched", 32'(wbyte(1, 5)), 0);
    op(1, 1, 0, 8'h07); op(1, 1, 0, 8'h17);
    check("R2 ch1 reg7", 32'(wbyte(1, 7)), 32'h17);
  endtask

  task automatic t_point_high;
    op(1, 1, 0, 8'h0B); op(1, 1, 0, 8'hB3);
    check("R3 ch1 reg11", 32'(wbyte(1, 11)), 32'hB3);
    check("R3 ch1 reg3 untouched", 32'(wbyte(1, 3)), 0);
    op(0, 1, 0, 8'h0E); op(0, 0, 1, 8'h00);
    check("R3 read reg14 data", 32'(c_rdata), 32'(sbyte(0, 14)));
    check("R7 read reg14 valid", 32'(c_rvalid), 1);
    op(0, 1, 0, 8'h08); op(0, 1, 0, 8'h88);
    check("R3 reg8", 32'(wbyte(0, 8)), 32'h88);
  endtask

  task automatic t_commands;
    for (int k = 2; k < 8; k++) begin
      op(0, 1, 0, 8'(k << 3));
      check("R5 cmd strobe", 32'(c_cmd), 32'(1 << (k - 2)));
      @(posedge clk); #1;
      check("R5 cmd one cycle", 32'(cmd_stb), 0);
    end
    op(1, 1, 0, 8'h28);
    check("R5 ch1 clear tx strobe", 32'(c_cmd), 32'(1 << 9));
    op(0, 1, 0, 8'h00);
    check("R5 code0 no strobe", 32'(c_cmd), 0);
    op(0, 1, 0, 8'h08);
    check("R5 point high no strobe", 32'(c_cmd), 0);
    op(0, 1, 0, 8'h00);
    check("R4 pointer consumed", 32'(wbyte(0, 8)), 0);
  endtask

  task automatic t_reset_codes;
    for (int r = 1; r < 4; r++) begin
      op(1, 1, 0, 8'(r << 6));
      check("R6 reset strobe", 32'(c_rst), 32'(1 << (3 + r - 1)));
      check("R6 no cmd", 32'(c_cmd), 0);
    end
    op(0, 1, 0, 8'h54);
    check("R6 combined rst", 32'(c_rst), 1);
    check("R6 combined cmd", 32'(c_cmd), 1);
    op(0, 1, 0, 8'h44);
    check("R6 combined select reg4", 32'(wbyte(0, 4)), 32'h44);
  endtask

  task automatic t_read_path;
    op(0, 1, 0, 8'h04); op(0, 0, 1, 8'h00);
    check("R7 read reg4 is status", 32'(c_rdata), 32'(sbyte(0, 4)));
    op(0, 0, 1, 8'h00);
    check("R4 R8 read after clears to reg0", 32'(c_rdata), 32'(sbyte(0, 0)));
    op(0, 0, 1, 8'h00);
    check("R8 reg0 again", 32'(c_rdata), 32'(sbyte(0, 0)));
    check("R8 valid", 32'(c_rvalid), 1);
  endtask

  task automatic t_shared;
    op(1, 1, 0, 8'h02); op(1, 1, 0, 8'h3E);
    check("R9 reg2 ch0", 32'(wbyte(0, 2)), 32'h3E);
    check("R9 reg2 ch1", 32'(wbyte(1, 2)), 32'h3E);
    op(0, 1, 0, 8'h09); op(0, 1, 0, 8'h91);
    check("R9 reg9 ch1", 32'(wbyte(1, 9)), 32'h91);
  endtask

  task automatic t_ipend;
    op(0, 1, 0, 8'h03); op(0, 0, 1, 8'h00);
    check("R10 ch0 reg3", 32'(c_rdata), 32'(sbyte(0, 3)));
    op(1, 1, 0, 8'h03); op(1, 0, 1, 8'h00);
    check("R10 ch1 reg3 blank", 32'(c_rdata), 0);
    check("R10 ch1 valid", 32'(c_rvalid), 1);
  endtask

  task automatic t_collide;
    op(0, 1, 0, 8'h06); op(0, 1, 1, 8'h66);
    check("R11 no rvalid", 32'(c_rvalid), 0);
    check("R11 write done", 32'(wbyte(0, 6)), 32'h66);
  endtask

  task automatic t_reg0;
    check("R12 ch0 reg0", 32'(wbyte(0, 0)), 0);
    check("R12 ch1 reg0", 32'(wbyte(1, 0)), 0);
  endtask

  task automatic t_hw_reset;
    op(1, 1, 0, 8'h06);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 reset wreg", 32'(wreg_q == '0), 1);
    op(1, 1, 0, 8'h28);
    check("R1 pointer cleared", 32'(c_cmd), 32'(1 << 9));
    check("R1 no data write", 32'(wbyte(1, 6)), 0);
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 16; i++)
        stat_rd[(c*16+i)*8 +: 8] = sbyte(c, i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_select_write;
    t_point_high;
    t_commands;
    t_reset_codes;
    t_read_path;
    t_shared;
    t_ipend;
    t_collide;
    t_reg0;
    t_hw_reset;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule